// File: doc/BRIEF.md
# Pipelined Binary-Trie Longest-Prefix Lookup

This block finds, for each destination address it receives, the next hop of the stored prefix that agrees with the greatest number of leading address bits. The prefixes sit in a binary trie. Next hops are stored only in leaves, and chains of nodes with a single child are folded into skip nodes. A skip node holds a short bit string that must equal the next address bits. The trie nodes are spread over a row of stages, one memory per stage. A node whose height is h lives in stage ADDR_W - h, so the root is early in the row and the leaves are at the end.

A lookup enters stage 0 with its address and a tag and moves forward one stage per cycle. A new lookup can enter on every cycle. A stage touches a lookup only when the lookup names that stage as the home of its next node. Otherwise the stage hands the lookup on unchanged, so a child may sit several stages ahead. Every lookup comes out a fixed number of cycles after it entered, in entry order, with a hit flag and a next hop.

Software rewrites the table with update bubbles. A bubble takes the place of one lookup slot and carries at most one node write for each stage. Each write lands in its stage on the cycle the bubble passes through that stage. Lookups that entered before the bubble therefore see the old table, and lookups that entered after it see the new table.

Top module: `trie_lpm`

## Requirements
- R1: A lookup is accepted in any cycle where lkValid is high and updValid is low. Its result appears with resValid high exactly STAGES = ADDR_W+1 cycles later, and resTag returns the request's tag. Lookups may be accepted on back-to-back cycles, and results leave in acceptance order. In every other cycle resValid is low.
- R2: When the walk ends on a leaf node, the result has resHit = 1 and resHop equal to that leaf's hop field. For a consistent table, this is the next hop of the longest stored prefix that matches the address.
- R3: The walk starts at node index 0 of stage 0 with bit position 0. An inner node (kind 2'b01) tests the address bit at the current position, counting from the most significant bit. A 0 follows the low child fields, a 1 follows the high child fields, and the position advances by one.
- R4: A skip node (kind 2'b10) compares the next jumpLen address bits with the top jumpLen bits of jumpBits, first bit at the highest bit. On a match the walk moves to the low child and the position advances by jumpLen; a jumpLen of 0 always matches. On a mismatch, or if the skip would run past the last address bit, the lookup becomes a miss. A miss gives resHit = 0 and resHop = 0.
- R5: An empty node (kind 2'b00) turns the lookup into a miss. Reset empties every stage, so lookups after reset miss until nodes are written.
- R6: A stage leaves a lookup unchanged unless the lookup's target stage equals that stage's number, so a child may be placed any number of stages later. A finished lookup (a hit or a miss) passes through the remaining stages without further reads.
- R7: When updValid is high, the slot becomes a write bubble. For each stage s with updEn[s] set, node word updNode[s*32 +: 32] is written at index updIdx[s*4 +: 4] of stage s. The bubble produces no result, and a lookup offered in the same cycle is dropped.
- R8: A lookup accepted before a bubble sees the table without that bubble's writes in every stage. A lookup accepted after the bubble sees the table with them.
- R9: While rst is high and on the cycle after, resValid is low.
- R10: The 32-bit node word is laid out as follows:
  - [31:30] kind
  - [29:26] lowIdx
  - [25:22] lowStg
  - [21:18] highIdx
  - [17:14] highStg
  - [13:11] jumpLen
  - [10:4] jumpBits
  - [3:0] hop

  A child stage that is not later than the current stage turns the lookup into a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the pipeline and all node memories |
| lkValid | input | 1 | Lookup request present this cycle |
| lkAddr | input | ADDR_W (8) | Destination address, most significant bit consumed first |
| lkTag | input | TAG_W (4) | Tag returned with the result |
| updValid | input | 1 | Inject an update bubble in this slot |
| updEn | input | STAGES (9) | Per-stage write enable of the bubble |
| updIdx | input | STAGES*IDX_W (36) | Per-stage node index, stage s at [s*4 +: 4] |
| updNode | input | STAGES*32 (288) | Per-stage node word, stage s at [s*32 +: 32] |
| resValid | output | 1 | Result present |
| resHit | output | 1 | A leaf was reached |
| resHop | output | HOP_W (4) | Next hop on a hit, zero on a miss |
| resTag | output | TAG_W (4) | Tag of the lookup this result belongs to |

## Verification
Every accepted lookup is due exactly nine cycles after the clock edge that accepted it. The bench stamps each expectation with that due cycle and samples the outputs on the falling edge of the due cycle. In every other cycle it requires resValid to be low. Bubble slots and dropped lookups get an entry that expects no result in their own slot. Each expectation is computed from a linear scan of the prefix list, as that list stands when the request is driven, and the list is changed at the moment a bubble is driven. Lookups placed immediately before and after a bubble therefore check the old-versus-new ordering.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  parameter int ADDR_W = 8;
  parameter int NODES  = 16;
  parameter int HOP_W  = 4;
  parameter int TAG_W  = 4;

  localparam int STAGES  = ADDR_W + 1;
  localparam int IDX_W   = $clog2(NODES);
  localparam int STG_W   = $clog2(STAGES);
  localparam int POS_W   = $clog2(ADDR_W + 1);
  localparam int JBITS_W = ADDR_W - 1;
  localparam int JLEN_W  = $clog2(ADDR_W);

  typedef enum logic [1:0] {
    NODE_EMPTY = 2'b00,
    NODE_INNER = 2'b01,
    NODE_JUMP  = 2'b10,
    NODE_LEAF  = 2'b11
  } node_kind_e;

  typedef struct packed {
    node_kind_e         kind;
    logic [IDX_W-1:0]   lowIdx;
    logic [STG_W-1:0]   lowStg;
    logic [IDX_W-1:0]   highIdx;
    logic [STG_W-1:0]   highStg;
    logic [JLEN_W-1:0]  jumpLen;
    logic [JBITS_W-1:0] jumpBits;
    logic [HOP_W-1:0]   hop;
  } node_t;

  localparam int NODE_W = $bits(node_t);

  typedef struct packed {
    logic              valid;
    logic              done;
    logic              hit;
    logic [HOP_W-1:0]  hop;
    logic [POS_W-1:0]  pos;
    logic [STG_W-1:0]  tgt;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
  } token_t;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
    node_t            node;
  } wr_t;

  typedef struct packed {
    logic takeLookup;
    logic takeBubble;
  } strobe_t;
endpackage

// File: rtl/lpm_stage.sv
module lpm_stage
  import lpm_pkg::*;
#(
  parameter int STAGE_NUM = 0
) (
  input  logic   clk,
  input  logic   rst,
  input  token_t tin,
  input  wr_t    wr,
  output token_t tout
);
  node_t              mem [NODES];
  node_t              nd;
  token_t             nxt;
  logic [ADDR_W-1:0]  shifted;
  logic [ADDR_W-1:0]  jumpMask;
  logic               jumpOk;
  logic [POS_W:0]     endPos;
  logic [IDX_W-1:0]   childIdx;
  logic [STG_W-1:0]   childStg;
  logic               mine;
  logic               fail;

  always_comb begin
    nd       = mem[tin.idx];
    shifted  = tin.addr << tin.pos;
    jumpMask = {~({JBITS_W{1'b1}} >> nd.jumpLen), 1'b0};
    jumpOk   = ((shifted ^ {nd.jumpBits, 1'b0}) & jumpMask) == '0;
    endPos   = {1'b0, tin.pos} + (POS_W+1)'(nd.jumpLen);
    childIdx = nd.lowIdx;
    childStg = nd.lowStg;
    if (nd.kind == NODE_INNER && shifted[ADDR_W-1]) begin
      childIdx = nd.highIdx;
      childStg = nd.highStg;
    end
    mine = tin.valid && !tin.done && (tin.tgt == STG_W'(STAGE_NUM));
    fail = (childStg <= STG_W'(STAGE_NUM))
        || (nd.kind == NODE_INNER && tin.pos >= POS_W'(ADDR_W))
        || (nd.kind == NODE_JUMP && (!jumpOk || endPos > (POS_W+1)'(ADDR_W)));
    nxt = tin;
    if (mine) begin
      case (nd.kind)
        NODE_LEAF: begin
          nxt.done = 1'b1;
          nxt.hit  = 1'b1;
          nxt.hop  = nd.hop;
        end
        NODE_INNER, NODE_JUMP: begin
          if (fail) begin
            nxt.done = 1'b1;
            nxt.hit  = 1'b0;
            nxt.hop  = '0;
          end else begin
            nxt.idx = childIdx;
            nxt.tgt = childStg;
            nxt.pos = (nd.kind == NODE_INNER) ? tin.pos + POS_W'(1) : endPos[POS_W-1:0];
          end
        end
        default: begin
          nxt.done = 1'b1;
          nxt.hit  = 1'b0;
          nxt.hop  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tout <= '0;
      for (int i = 0; i < NODES; i++) mem[i] <= '0;
    end else begin
      tout <= nxt;
      if (wr.en) mem[wr.idx] <= wr.node;
    end
  end
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  strobe_t                   strb,
  input  logic [ADDR_W-1:0]         lkAddr,
  input  logic [TAG_W-1:0]          lkTag,
  input  logic [STAGES-1:0]         updEn,
  input  logic [STAGES*IDX_W-1:0]   updIdx,
  input  logic [STAGES*NODE_W-1:0]  updNode,
  output token_t                    lastTok
);
  token_t tok     [STAGES+1];
  wr_t    entryWr [STAGES];
  wr_t    stageWr [STAGES];

  always_comb begin
    tok[0]       = '0;
    tok[0].valid = strb.takeLookup;
    tok[0].addr  = lkAddr;
    tok[0].tag   = lkTag;
    for (int s = 0; s < STAGES; s++) begin
      entryWr[s].en   = strb.takeBubble & updEn[s];
      entryWr[s].idx  = updIdx[s*IDX_W +: IDX_W];
      entryWr[s].node = updNode[s*NODE_W +: NODE_W];
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_direct
      assign stageWr[s] = entryWr[s];
    end else begin : g_delay
      wr_t line [s];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < s; k++) line[k] <= '0;
        end else begin
          line[0] <= entryWr[s];
          for (int k = 1; k < s; k++) line[k] <= line[k-1];
        end
      end
      assign stageWr[s] = line[s-1];
    end

    lpm_stage #(.STAGE_NUM(s)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .tin  (tok[s]),
      .wr   (stageWr[s]),
      .tout (tok[s+1])
    );
  end

  assign lastTok = tok[STAGES];
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic    lkValid,
  input  logic    updValid,
  output strobe_t strb
);
  always_comb begin
    strb.takeBubble = updValid;
    strb.takeLookup = lkValid && !updValid;
  end
endmodule

// File: rtl/trie_lpm.sv
module trie_lpm
  import lpm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lkValid,
  input  logic [ADDR_W-1:0]         lkAddr,
  input  logic [TAG_W-1:0]          lkTag,
  input  logic                      updValid,
  input  logic [STAGES-1:0]         updEn,
  input  logic [STAGES*IDX_W-1:0]   updIdx,
  input  logic [STAGES*NODE_W-1:0]  updNode,
  output logic                      resValid,
  output logic                      resHit,
  output logic [HOP_W-1:0]          resHop,
  output logic [TAG_W-1:0]          resTag
);
  strobe_t strb;
  token_t  lastTok;

  lpm_ctrl u_ctrl (
    .lkValid  (lkValid),
    .updValid (updValid),
    .strb     (strb)
  );

  lpm_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .lkAddr  (lkAddr),
    .lkTag   (lkTag),
    .updEn   (updEn),
    .updIdx  (updIdx),
    .updNode (updNode),
    .lastTok (lastTok)
  );

  assign resValid = lastTok.valid;
  assign resHit   = lastTok.valid && lastTok.done && lastTok.hit;
  assign resHop   = resHit ? lastTok.hop : '0;
  assign resTag   = lastTok.tag;
endmodule

// File: rtl/trie_lpm_chk.sv
module trie_lpm_chk
  import lpm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              lkValid,
  input logic [TAG_W-1:0]  lkTag,
  input logic              updValid,
  input logic [STAGES-1:0] updEn,
  input logic              resValid,
  input logic              resHit,
  input logic [HOP_W-1:0]  resHop,
  input logic [TAG_W-1:0]  resTag
);
  logic [STAGES-1:0] accSr;
  logic [STAGES-1:0] cleanSr;
  logic [TAG_W-1:0]  tagSr [STAGES];
  logic              sawWrite;
  logic              accept;

  assign accept = lkValid && !updValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      accSr    <= '0;
      cleanSr  <= '0;
      sawWrite <= 1'b0;
      for (int i = 0; i < STAGES; i++) tagSr[i] <= '0;
    end else begin
      accSr    <= {accSr[STAGES-2:0], accept};
      cleanSr  <= {cleanSr[STAGES-2:0], accept && !sawWrite};
      sawWrite <= sawWrite || (updValid && (|updEn));
      tagSr[0] <= lkTag;
      for (int i = 1; i < STAGES; i++) tagSr[i] <= tagSr[i-1];
    end
  end

  // R1: result valid exactly STAGES cycles after acceptance
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    resValid == accSr[STAGES-1]);

  // R1: tags return in acceptance order
  a_r1_tag_order: assert property (@(posedge clk) disable iff (rst)
    resValid |-> resTag == tagSr[STAGES-1]);

  // R5: lookups accepted before any node was written always miss
  a_r5_empty_until_written: assert property (@(posedge clk) disable iff (rst)
    (resValid && cleanSr[STAGES-1]) |-> !resHit);

  // R4: a miss carries a zero hop
  a_r4_miss_no_hop: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resHit) |-> resHop == '0);
endmodule

bind trie_lpm trie_lpm_chk u_chk (.*);

// File: tb/trie_lpm_tb.sv
`timescale 1ns/1ps
module trie_lpm_tb;
  import lpm_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lkValid = 1'b0;
  logic [ADDR_W-1:0] lkAddr = '0;
  logic [TAG_W-1:0] lkTag = '0;
  logic updValid = 1'b0;
  logic [STAGES-1:0] updEn = '0;
  logic [STAGES*IDX_W-1:0] updIdx = '0;
  logic [STAGES*NODE_W-1:0] updNode = '0;
  logic resValid, resHit;
  logic [HOP_W-1:0] resHop;
  logic [TAG_W-1:0] resTag;

  trie_lpm u_dut (.*);

  always #5 clk = ~clk;

  int pc = 0;
  int nTests = 0;
  int nFail = 0;
  int tagCnt = 0;
  bit finished = 0;

  always @(posedge clk) pc <= pc + 1;

  int    dueQ[$];
  bit    dropQ[$];
  int    expQ[$];
  string reqQ[$];

  int pVal[4];
  int pLen[4];
  int pHop[4];
  bit pOn[4];

  logic [STAGES-1:0] bEn;
  logic [IDX_W-1:0]  bIdx [STAGES];
  logic [NODE_W-1:0] bNode [STAGES];

  function automatic void refLookup(input int a, output bit h, output int hp);
    int best;
    best = 0;
    h = 0;
    hp = 0;
    for (int i = 0; i < 4; i++) begin
      if (pOn[i] && ((a >> (ADDR_W - pLen[i])) == pVal[i]) && pLen[i] > best) begin
        best = pLen[i];
        h = 1;
        hp = pHop[i];
      end
    end
  endfunction

  // R10 layout: kind, lowIdx, lowStg, highIdx, highStg, jumpLen, jumpBits, hop
  function automatic logic [31:0] mkNode(input int kind, input int li, input int ls,
                                         input int hi, input int hs, input int jl,
                                         input int jb, input int hop);
    return {kind[1:0], li[3:0], ls[3:0], hi[3:0], hs[3:0], jl[2:0], jb[6:0], hop[3:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (pc=%0d)", req, act, exp, pc);
    end
  endtask

  always @(negedge clk) begin : mon
    int act;
    if (!finished) begin
      act = {22'd0, resValid, resHit, resHop, resTag};
      if (dueQ.size() > 0 && dueQ[0] == pc) begin
        if (dropQ[0]) check(resValid == 1'b0, reqQ[0], act, 0);
        else          check(act == expQ[0], reqQ[0], act, expQ[0]);
        void'(dueQ.pop_front());
        void'(dropQ.pop_front());
        void'(expQ.pop_front());
        void'(reqQ.pop_front());
      end else begin
        if (rst) check(resValid == 1'b0, "R9", act, 0);
        else     check(resValid == 1'b0, "R1", act, 0);
      end
    end
  end

  task automatic clearB();
    bEn = '0;
    for (int s = 0; s < STAGES; s++) begin
      bIdx[s] = '0;
      bNode[s] = '0;
    end
  endtask

  task automatic putB(input int s, input int idx, input logic [31:0] n);
    bEn[s] = 1'b1;
    bIdx[s] = idx[IDX_W-1:0];
    bNode[s] = n;
  endtask

  task automatic sendBubble(input bit withLookup, input logic [7:0] a, input string req);
    @(negedge clk);
    lkValid = withLookup;
    lkAddr = a;
    lkTag = tagCnt[3:0];
    updValid = 1'b1;
    updEn = bEn;
    for (int s = 0; s < STAGES; s++) begin
      updIdx[s*IDX_W +: IDX_W] = bIdx[s];
      updNode[s*NODE_W +: NODE_W] = bNode[s];
    end
    dueQ.push_back(pc + STAGES);
    dropQ.push_back(1'b1);
    expQ.push_back(0);
    reqQ.push_back(req);
  endtask

  task automatic lookup(input logic [7:0] a, input string req);
    bit h;
    int hp;
    @(negedge clk);
    lkValid = 1'b1;
    updValid = 1'b0;
    updEn = '0;
    lkAddr = a;
    lkTag = tagCnt[3:0];
    refLookup(int'(a), h, hp);
    dueQ.push_back(pc + STAGES);
    dropQ.push_back(1'b0);
    expQ.push_back({22'd0, 1'b1, h, hp[3:0], tagCnt[3:0]});
    reqQ.push_back(req);
    tagCnt++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      lkValid = 1'b0;
      updValid = 1'b0;
      updEn = '0;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", pc, 200000);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : stim
    pVal = '{1, 5, 13, 0};
    pLen = '{1, 3, 5, 2};
    pHop = '{1, 2, 3, 4};
    pOn  = '{0, 0, 0, 0};
    clearB();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R5: empty memories after reset, every lookup misses
    lookup(8'hA0, "R5");
    lookup(8'h00, "R5");
    lookup(8'h68, "R5");

    // R7: load the trie, one node per stage per bubble
    clearB();
    putB(0, 0, mkNode(2, 0, 5, 0, 0, 0, 0, 0));
    putB(5, 0, mkNode(1, 0, 6, 1, 6, 0, 0, 0));
    putB(6, 0, mkNode(1, 0, 8, 0, 7, 0, 0, 0));
    putB(7, 0, mkNode(2, 1, 8, 0, 0, 3, 7'b1010000, 0));
    putB(8, 0, mkNode(3, 0, 0, 0, 0, 0, 0, 4));
    sendBubble(0, 8'h00, "R7");
    clearB();
    putB(6, 1, mkNode(1, 1, 7, 4, 8, 0, 0, 0));
    putB(7, 1, mkNode(1, 3, 8, 2, 8, 0, 0, 0));
    putB(8, 1, mkNode(3, 0, 0, 0, 0, 0, 0, 3));
    sendBubble(0, 8'h00, "R7");
    clearB();
    putB(8, 2, mkNode(3, 0, 0, 0, 0, 0, 0, 2));
    sendBubble(0, 8'h00, "R7");
    clearB();
    putB(8, 3, mkNode(3, 0, 0, 0, 0, 0, 0, 1));
    sendBubble(0, 8'h00, "R7");
    clearB();
    putB(8, 4, mkNode(3, 0, 0, 0, 0, 0, 0, 1));
    sendBubble(0, 8'h00, "R7");
    pOn = '{1, 1, 1, 1};
    idle(2);

    // R2 / R3: inner-node walks to leaves
    lookup(8'h12, "R3");
    lookup(8'hB7, "R2");
    lookup(8'h80, "R2");
    lookup(8'hC5, "R3");
    lookup(8'h9F, "R2");

    // R4: skip node match and mismatch
    lookup(8'h68, "R4");
    lookup(8'h60, "R4");
    lookup(8'h78, "R4");
    lookup(8'h6F, "R4");

    // R6: root reached through pass-through stages, mismatch after skip
    lookup(8'h4F, "R6");
    idle(1);

    // R1: back-to-back stream
    for (int i = 0; i < 16; i++) lookup(8'(i * 17), "R1");

    // R8: lookup, bubble, lookup on adjacent cycles
    lookup(8'hA5, "R8");
    clearB();
    putB(8, 2, mkNode(3, 0, 0, 0, 0, 0, 0, 6));
    sendBubble(0, 8'h00, "R8");
    pHop[1] = 6;
    lookup(8'hA5, "R8");

    // R7: lookup offered together with a bubble is dropped
    clearB();
    sendBubble(1, 8'hA5, "R7");
    lookup(8'hA5, "R7");

    // R5: deleting a leaf leaves an empty node
    clearB();
    putB(8, 0, mkNode(0, 0, 0, 0, 0, 0, 0, 0));
    sendBubble(0, 8'h00, "R5");
    pOn[3] = 0;
    lookup(8'h12, "R5");
    lookup(8'h3C, "R5");

    // R7 / R4: one bubble rewrites two stages
    clearB();
    putB(7, 0, mkNode(2, 1, 8, 0, 0, 2, 7'b1000000, 0));
    putB(8, 1, mkNode(3, 0, 0, 0, 0, 0, 0, 7));
    sendBubble(0, 8'h00, "R7");
    pVal[2] = 6;
    pLen[2] = 4;
    pHop[2] = 7;
    lookup(8'h60, "R7");
    lookup(8'h6C, "R4");
    lookup(8'h70, "R4");

    idle(STAGES + 3);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule